// File: doc/BRIEF.md
# Split instruction/data TLB lookup with protection checks

This block holds two translation buffers side by side, one serving instruction fetches and one serving data accesses. Each is organised as four ways of sixteen entries, and every entry is a pair of 32-bit words: a tag word and an attribute word. A lookup request carries a virtual address, the current 8-bit address-space identifier, an access kind, a user-mode flag, a configuration word and a victim way chosen outside the block. The block probes the indexed slot in every way of the selected buffer. If an entry matches, the block either grants the access with a physical address or raises a protection fault. If no entry matches, the block reports a refill fault.

Faults return a vector number. Each buffer has its own bank of vectors. On every fault the block latches a cause word. On a refill fault it also latches the slot to be refilled. Whenever an entry matched, its two words are copied into a pair of readable registers. A separate write port loads entries. Walking page tables is left to software or to another block.

Top module: `tlb_guard`

## Requirements
- R1: While reset is asserted, and until the first request completes, rsp_valid_o, hit_o and fault_o are 0, and vec_o, paddr_o, cause_o, sel_o, ent_hi_o, ent_lo_o and every stored entry are 0.
- R2: The write port stores wr_hi_i/wr_lo_i into bank wr_bank_i (0 = instruction, 1 = data), way wr_way_i, slot wr_idx_i at the clock edge. A request presented in that same cycle still sees the old contents. A request in any later cycle sees the new contents.
- R3: Access codes are 0 read, 1 write, 2 execute and 3 treated as read. Execute probes the instruction bank and all other codes probe the data bank, at slot vaddr_i[16:13]. An entry matches when tag[31:13] equals vaddr_i[31:13] and either attribute bit 4 (global) is set or tag[7:0] equals pid_i.
- R4: When more than one way matches, the lowest-numbered way is used.
- R5: A granted access gives hit_o=1, fault_o=0, vec_o=0 and paddr_o = {attribute[31:13], vaddr_i[12:0]}.
- R6: For a matching entry, faults are tested in this order, and the first that applies wins. Attribute bits are valid 3, kernel 2, writable 1, executable 0. Config enables are cfg_i[18] kernel, cfg_i[19] write, cfg_i[17] execute, cfg_i[16] valid. The tests are: kernel (enable, entry kernel bit and user_i) gives offset 2; write (write access, enable, entry not writable) gives offset 3; execute (execute access, enable, entry not executable) gives offset 3; invalid (enable, entry valid bit clear) gives offset 1. The vector is 4 + offset for the instruction bank and 8 + offset for the data bank. On any fault, fault_o=1, hit_o=0 and paddr_o=0.
- R7: A miss gives fault_o=1, vec_o = 4 (instruction) or 8 (data), and loads sel_o with victim_i in bits [5:4] and the slot index in bits [3:0].
- R8: Every fault, protection or miss, loads cause_o with vaddr_i[31:13] in [31:13], the access code in [9:8] (code 3 recorded as 0), pid_i in [7:0] and zeros elsewhere. A granted access leaves cause_o unchanged.
- R9: When an entry matched, whether the access was granted or faulted, ent_hi_o and ent_lo_o take that entry's words. A miss leaves them unchanged.
- R10: rsp_valid_o is high exactly in the cycle after a cycle with req_i high. The result outputs change only after a request and hold between requests.
- R11: sel_o changes only on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry load strobe |
| wr_bank_i | input | 1 | Bank to load: 0 instruction, 1 data |
| wr_way_i | input | 2 | Way to load |
| wr_idx_i | input | 4 | Slot to load |
| wr_hi_i | input | 32 | Tag word to store |
| wr_lo_i | input | 32 | Attribute word to store |
| req_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address |
| pid_i | input | 8 | Current address-space identifier |
| acc_i | input | 2 | Access kind |
| user_i | input | 1 | Access made in user mode |
| cfg_i | input | 32 | Protection enable word |
| victim_i | input | 2 | Way proposed for refill |
| rsp_valid_o | output | 1 | Result strobe |
| hit_o | output | 1 | Access granted |
| fault_o | output | 1 | Access faulted |
| vec_o | output | 4 | Fault vector number |
| paddr_o | output | 32 | Physical address on grant |
| cause_o | output | 32 | Latched fault cause |
| sel_o | output | 6 | Latched refill slot |
| ent_hi_o | output | 32 | Copy of matched tag word |
| ent_lo_o | output | 32 | Copy of matched attribute word |

## Verification
Every result, including the cause, slot and entry-copy registers, is due at the first rising edge after the request edge. The block has one register stage and no bypass. A load is seen by a request from the cycle after the load, never in the same cycle. The bench's model updates its expected values at the same edge the design does and applies loads only after it has evaluated that edge's request. All outputs are then compared at the following falling edge, every cycle, so outputs that hold between requests are checked as well.

// File: rtl/tlb_guard_pkg.sv
package tlb_guard_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned PAGE_SHIFT = 13;
  localparam int unsigned VPN_W      = WORD_W - PAGE_SHIFT;
  localparam int unsigned PID_W      = 8;
  localparam int unsigned BANKS      = 2;

  localparam int unsigned CFG_V_BIT = 16;
  localparam int unsigned CFG_X_BIT = 17;
  localparam int unsigned CFG_K_BIT = 18;
  localparam int unsigned CFG_W_BIT = 19;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [4:0]       rsvd;
    logic [PID_W-1:0] pid;
  } tag_t;

  typedef struct packed {
    logic [VPN_W-1:0] pfn;
    logic [7:0]       rsvd;
    logic             glob;
    logic             vld;
    logic             kern;
    logic             wr;
    logic             ex;
  } attr_t;

  typedef enum logic [2:0] {
    VD_GRANT,
    VD_MISS,
    VD_KERN,
    VD_WPROT,
    VD_XPROT,
    VD_INVAL
  } verdict_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_guard_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 16,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic                           wr_bank_i,
  input  logic [WAY_W-1:0]               wr_way_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [WORD_W-1:0]              wr_hi_i,
  input  logic [WORD_W-1:0]              wr_lo_i,
  input  logic                           rd_bank_i,
  input  logic [IDX_W-1:0]               rd_idx_i,
  output logic [WAYS-1:0][WORD_W-1:0]    rd_hi_o,
  output logic [WAYS-1:0][WORD_W-1:0]    rd_lo_o
);
  logic [WORD_W-1:0] bank_hi [BANKS][WAYS];
  logic [WORD_W-1:0] bank_lo [BANKS][WAYS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [WORD_W-1:0] hi_q [SETS];
      logic [WORD_W-1:0] lo_q [SETS];
      logic              we;

      assign we = wr_en_i && (wr_bank_i == 1'(b)) && (wr_way_i == WAY_W'(w));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int s = 0; s < SETS; s++) begin
            hi_q[s] <= '0;
            lo_q[s] <= '0;
          end
        end else if (we) begin
          hi_q[wr_idx_i] <= wr_hi_i;
          lo_q[wr_idx_i] <= wr_lo_i;
        end
      end

      assign bank_hi[b][w] = hi_q[rd_idx_i];
      assign bank_lo[b][w] = lo_q[rd_idx_i];
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_hi_o[w] = bank_hi[rd_bank_i][w];
      rd_lo_o[w] = bank_lo[rd_bank_i][w];
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_guard_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WORD_W-1:0] hi_i,
  input  logic [WAYS-1:0][WORD_W-1:0] lo_i,
  input  logic [VPN_W-1:0]            vpn_i,
  input  logic [PID_W-1:0]            pid_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o,
  output logic [WORD_W-1:0]           hi_o,
  output logic [WORD_W-1:0]           lo_o
);
  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    tag_t  tg;
    attr_t at;
    assign tg = tag_t'(hi_i[w]);
    assign at = attr_t'(lo_i[w]);
    assign way_hit[w] = (tg.vpn == vpn_i) && (at.glob || (tg.pid == pid_i));
  end

  // lowest way wins: scan downward so the last assignment is the smallest
  always_comb begin
    hit_o = |way_hit;
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) way_o = WAY_W'(w);
    end
    hi_o = hi_i[way_o];
    lo_o = lo_i[way_o];
  end
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
  import tlb_guard_pkg::*;
(
  input  logic              hit_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  input  logic [WORD_W-1:0] cfg_i,
  output verdict_e          verdict_o
);
  attr_t at;
  assign at = attr_t'(lo_i);

  always_comb begin
    if (!hit_i)
      verdict_o = VD_MISS;
    else if (cfg_i[CFG_K_BIT] && at.kern && user_i)
      verdict_o = VD_KERN;
    else if (acc_i == ACC_WRITE && cfg_i[CFG_W_BIT] && !at.wr)
      verdict_o = VD_WPROT;
    else if (acc_i == ACC_EXEC && cfg_i[CFG_X_BIT] && !at.ex)
      verdict_o = VD_XPROT;
    else if (cfg_i[CFG_V_BIT] && !at.vld)
      verdict_o = VD_INVAL;
    else
      verdict_o = VD_GRANT;
  end
endmodule

// File: rtl/tlb_guard.sv
module tlb_guard
  import tlb_guard_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 16,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned SEL_W = WAY_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_hi_i,
  input  logic [WORD_W-1:0] wr_lo_i,
  input  logic              req_i,
  input  logic [WORD_W-1:0] vaddr_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  input  logic [WORD_W-1:0] cfg_i,
  input  logic [WAY_W-1:0]  victim_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              fault_o,
  output logic [3:0]        vec_o,
  output logic [WORD_W-1:0] paddr_o,
  output logic [WORD_W-1:0] cause_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [WORD_W-1:0] ent_hi_o,
  output logic [WORD_W-1:0] ent_lo_o
);
  logic                        bank;
  logic [IDX_W-1:0]            idx;
  logic [VPN_W-1:0]            vpn;
  logic [WAYS-1:0][WORD_W-1:0] way_hi, way_lo;
  logic                        match;
  logic [WAY_W-1:0]            match_way;
  logic [WORD_W-1:0]           m_hi, m_lo;
  verdict_e                    verdict;
  logic [1:0]                  vec_off;
  logic [3:0]                  vec_d;
  logic [1:0]                  cause_acc;
  attr_t                       m_at;

  assign bank = (acc_i != ACC_EXEC);
  assign vpn  = vaddr_i[WORD_W-1:PAGE_SHIFT];
  assign idx  = vaddr_i[PAGE_SHIFT +: IDX_W];

  tlb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_bank_i (wr_bank_i),
    .wr_way_i  (wr_way_i),
    .wr_idx_i  (wr_idx_i),
    .wr_hi_i   (wr_hi_i),
    .wr_lo_i   (wr_lo_i),
    .rd_bank_i (bank),
    .rd_idx_i  (idx),
    .rd_hi_o   (way_hi),
    .rd_lo_o   (way_lo)
  );

  tlb_match #(.WAYS(WAYS)) u_match (
    .hi_i  (way_hi),
    .lo_i  (way_lo),
    .vpn_i (vpn),
    .pid_i (pid_i),
    .hit_o (match),
    .way_o (match_way),
    .hi_o  (m_hi),
    .lo_o  (m_lo)
  );

  tlb_prot u_prot (
    .hit_i     (match),
    .lo_i      (m_lo),
    .acc_i     (acc_i),
    .user_i    (user_i),
    .cfg_i     (cfg_i),
    .verdict_o (verdict)
  );

  assign m_at = attr_t'(m_lo);

  always_comb begin
    unique case (verdict)
      VD_INVAL:           vec_off = 2'd1;
      VD_KERN:            vec_off = 2'd2;
      VD_WPROT, VD_XPROT: vec_off = 2'd3;
      default:            vec_off = 2'd0;
    endcase
    vec_d     = {bank ? 2'b10 : 2'b01, vec_off};
    cause_acc = (acc_i == ACC_ALT) ? 2'd0 : acc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      fault_o     <= 1'b0;
      vec_o       <= '0;
      paddr_o     <= '0;
      cause_o     <= '0;
      sel_o       <= '0;
      ent_hi_o    <= '0;
      ent_lo_o    <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        hit_o   <= (verdict == VD_GRANT);
        fault_o <= (verdict != VD_GRANT);
        vec_o   <= (verdict == VD_GRANT) ? 4'd0 : vec_d;
        paddr_o <= (verdict == VD_GRANT) ? {m_at.pfn, vaddr_i[PAGE_SHIFT-1:0]} : '0;
        if (verdict != VD_GRANT)
          cause_o <= {vpn, 3'b000, cause_acc, pid_i};
        if (verdict == VD_MISS)
          sel_o <= {victim_i, idx};
        if (match) begin
          ent_hi_o <= m_hi;
          ent_lo_o <= m_lo;
        end
      end
    end
  end

  p_rsp_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  p_no_spurious_rsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  p_hit_xor_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (hit_o ^ fault_o));
  p_vec_bank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (fault_o |-> vec_o[3:2] == (($past(acc_i) == ACC_EXEC) ? 2'b01 : 2'b10)));
  p_paddr_offset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (hit_o |-> paddr_o[PAGE_SHIFT-1:0] == $past(vaddr_i[PAGE_SHIFT-1:0])));
  p_cause_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && hit_o) |-> $stable(cause_o));
  p_sel_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && fault_o && vec_o[1:0] == 2'b00) |-> $stable(sel_o));
  p_sel_victim_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ((fault_o && vec_o[1:0] == 2'b00) |-> sel_o[SEL_W-1:IDX_W] == $past(victim_i)));
endmodule

// File: tb/sim_tlb_guard.sv
module sim_tlb_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_bank_i = 1'b0;
  logic [1:0]  wr_way_i = '0;
  logic [3:0]  wr_idx_i = '0;
  logic [31:0] wr_hi_i = '0, wr_lo_i = '0;
  logic        req_i = 1'b0, user_i = 1'b0;
  logic [31:0] vaddr_i = '0, cfg_i = '0;
  logic [7:0]  pid_i = '0;
  logic [1:0]  acc_i = '0, victim_i = '0;
  logic        rsp_valid_o, hit_o, fault_o;
  logic [3:0]  vec_o;
  logic [31:0] paddr_o, cause_o, ent_hi_o, ent_lo_o;
  logic [5:0]  sel_o;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  always #4 clk_i = ~clk_i;

  tlb_guard u0 (.*);

  // behavioural reference
  logic [31:0] m_hi [2][4][16];
  logic [31:0] m_lo [2][4][16];
  logic        e_valid, e_hit, e_fault;
  logic [3:0]  e_vec;
  logic [31:0] e_paddr, e_cause, e_hi, e_lo;
  logic [5:0]  e_sel;
  int          r_bank, r_idx, r_way, r_off;
  logic [31:0] t_hi, t_lo;

  initial begin
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 16; s++) begin
          m_hi[b][w][s] = '0;
          m_lo[b][w][s] = '0;
        end
    e_valid = 0; e_hit = 0; e_fault = 0; e_vec = 0;
    e_paddr = 0; e_cause = 0; e_hi = 0; e_lo = 0; e_sel = 0;
  end

  always @(posedge clk_i) begin
    if (rst_ni) begin
      e_valid = req_i;
      if (req_i) begin
        r_bank = (acc_i == 2) ? 0 : 1;
        r_idx  = int'(vaddr_i[16:13]);
        r_way  = -1;
        for (int w = 0; w < 4; w++) begin
          t_hi = m_hi[r_bank][w][r_idx];
          t_lo = m_lo[r_bank][w][r_idx];
          if (r_way < 0 && t_hi[31:13] == vaddr_i[31:13] && (t_lo[4] || t_hi[7:0] == pid_i))
            r_way = w;
        end
        if (r_way < 0) r_off = 0;
        else begin
          t_hi = m_hi[r_bank][r_way][r_idx];
          t_lo = m_lo[r_bank][r_way][r_idx];
          e_hi = t_hi;
          e_lo = t_lo;
          if (cfg_i[18] && t_lo[2] && user_i) r_off = 2;
          else if (acc_i == 1 && cfg_i[19] && !t_lo[1]) r_off = 3;
          else if (acc_i == 2 && cfg_i[17] && !t_lo[0]) r_off = 3;
          else if (cfg_i[16] && !t_lo[3]) r_off = 1;
          else r_off = -1;
        end
        if (r_off < 0) begin
          e_hit = 1; e_fault = 0; e_vec = 0;
          e_paddr = {t_lo[31:13], vaddr_i[12:0]};
        end else begin
          e_hit = 0; e_fault = 1; e_paddr = 0;
          e_vec = 4'((r_bank == 0 ? 4 : 8) + r_off);
          e_cause = {vaddr_i[31:13], 3'b000, (acc_i == 3) ? 2'd0 : acc_i, pid_i};
          if (r_way < 0) e_sel = {victim_i, vaddr_i[16:13]};
        end
      end
      if (wr_en_i) begin
        m_hi[wr_bank_i][wr_way_i][wr_idx_i] = wr_hi_i;
        m_lo[wr_bank_i][wr_way_i][wr_idx_i] = wr_lo_i;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (running) begin
      chk("R10 rsp_valid", 32'(rsp_valid_o), 32'(e_valid));
      chk("R3/R4 hit", 32'(hit_o), 32'(e_hit));
      chk("R6 fault", 32'(fault_o), 32'(e_fault));
      chk("R6 vec", 32'(vec_o), 32'(e_vec));
      chk("R5 paddr", paddr_o, e_paddr);
      chk("R8 cause", cause_o, e_cause);
      chk("R7/R11 sel", 32'(sel_o), 32'(e_sel));
      chk("R9 ent_hi", ent_hi_o, e_hi);
      chk("R9 ent_lo", ent_lo_o, e_lo);
    end
  end

  function automatic logic [31:0] mk_hi(logic [18:0] vpn, logic [7:0] pid);
    return {vpn, 5'b0, pid};
  endfunction
  function automatic logic [31:0] mk_lo(logic [18:0] pfn, logic g, v, k, w, x);
    return {pfn, 8'b0, g, v, k, w, x};
  endfunction

  task automatic load(logic b, logic [1:0] w, logic [3:0] i, logic [31:0] hi, logic [31:0] lo);
    wr_en_i = 1; wr_bank_i = b; wr_way_i = w; wr_idx_i = i; wr_hi_i = hi; wr_lo_i = lo;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] pid, logic [1:0] acc, logic usr,
                      logic [31:0] cfg, logic [1:0] vic);
    req_i = 1; vaddr_i = va; pid_i = pid; acc_i = acc; user_i = usr; cfg_i = cfg; victim_i = vic;
    @(negedge clk_i);
    req_i = 0;
    @(negedge clk_i);
  endtask

  localparam logic [31:0] CFG_ALL = 32'h000F_0000;

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset values, observed while reset is held
    chk("R1 rsp_valid", 32'(rsp_valid_o), 0);
    chk("R1 hit", 32'(hit_o), 0);
    chk("R1 fault", 32'(fault_o), 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 sel", 32'(sel_o), 0);
    chk("R1 ent_lo", ent_lo_o, 0);
    rst_ni = 1;
    running = 1;
    @(negedge clk_i);

    // R2/R3/R5: instruction bank hit on pid match
    load(0, 0, 4'd1, mk_hi(19'h00001, 8'h05), mk_lo(19'h00100, 0, 1, 0, 0, 1));
    look(32'h0000_2123, 8'h05, 2, 0, CFG_ALL, 2'd2);
    // R7: pid mismatch misses, slot from victim
    look(32'h0000_2123, 8'h06, 2, 0, CFG_ALL, 2'd2);
    // R3: global data entry ignores pid
    load(1, 1, 4'd2, mk_hi(19'h40002, 8'h77), mk_lo(19'h12345, 1, 1, 0, 1, 0));
    look(32'h8000_4abc, 8'h09, 0, 1, CFG_ALL, 2'd0);
    // R4: two ways match, lower way supplies the frame
    load(1, 3, 4'd3, mk_hi(19'h00003, 8'h01), mk_lo(19'h00333, 0, 1, 0, 1, 1));
    load(1, 2, 4'd3, mk_hi(19'h00003, 8'h01), mk_lo(19'h00222, 0, 1, 0, 1, 1));
    look(32'h0000_6010, 8'h01, 0, 0, CFG_ALL, 2'd1);
    // R6: kernel beats write protection
    load(1, 0, 4'd4, mk_hi(19'h00004, 8'h01), mk_lo(19'h00444, 0, 1, 1, 0, 0));
    look(32'h0000_8000, 8'h01, 1, 1, CFG_ALL, 2'd3);
    look(32'h0000_8000, 8'h01, 1, 0, CFG_ALL, 2'd3);
    look(32'h0000_8000, 8'h01, 1, 0, 32'h0007_0000, 2'd3);
    // R6: execute fault in instruction bank
    load(0, 1, 4'd5, mk_hi(19'h00005, 8'h01), mk_lo(19'h00555, 0, 1, 0, 1, 0));
    look(32'h0000_a000, 8'h01, 2, 0, CFG_ALL, 2'd0);
    // R6: invalid entry, then with valid check disabled
    load(1, 0, 4'd6, mk_hi(19'h00006, 8'h01), mk_lo(19'h00666, 0, 0, 0, 1, 1));
    look(32'h0000_c000, 8'h01, 0, 0, CFG_ALL, 2'd0);
    look(32'h0000_c000, 8'h01, 3, 0, 32'h000E_0000, 2'd0);
    // R2: load and request in the same cycle, request sees old contents
    wr_en_i = 1; wr_bank_i = 1; wr_way_i = 1; wr_idx_i = 4'd7;
    wr_hi_i = mk_hi(19'h00007, 8'h02); wr_lo_i = mk_lo(19'h00777, 0, 1, 0, 1, 1);
    req_i = 1; vaddr_i = 32'h0000_e000; pid_i = 8'h02; acc_i = 3; victim_i = 2'd1; cfg_i = CFG_ALL;
    @(negedge clk_i);
    wr_en_i = 0; req_i = 0;
    look(32'h0000_e000, 8'h02, 0, 0, CFG_ALL, 2'd1);

    // mixed traffic over a small tag pool
    for (int n = 0; n < 600; n++) begin
      logic [18:0] vp;
      vp = {($urandom_range(0, 1) == 1) ? 15'h7fff : 15'h0000, 4'($urandom_range(0, 3))};
      wr_en_i = ($urandom_range(0, 9) < 3);
      wr_bank_i = 1'($urandom_range(0, 1));
      wr_way_i = 2'($urandom_range(0, 3));
      wr_idx_i = vp[3:0];
      wr_hi_i = mk_hi(vp, 8'($urandom_range(0, 3)));
      wr_lo_i = $urandom;
      vp = {($urandom_range(0, 1) == 1) ? 15'h7fff : 15'h0000, 4'($urandom_range(0, 3))};
      req_i = ($urandom_range(0, 9) < 7);
      vaddr_i = {vp, 13'($urandom)};
      pid_i = 8'($urandom_range(0, 3));
      acc_i = 2'($urandom_range(0, 3));
      user_i = 1'($urandom_range(0, 1));
      cfg_i = {12'h0, 4'($urandom), 16'h0};
      victim_i = 2'($urandom_range(0, 3));
      @(negedge clk_i);
    end
    wr_en_i = 0; req_i = 0;
    repeat (2) @(negedge clk_i);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule